// File: doc/BRIEF.md
# Next-PC and Exception-Entry Unit

This block decides where a 32-bit RISC core fetches next. Each cycle that `validIn` is high it takes the current PC, the opcode, function and low 26 bits of the instruction word, the two source operand values and a syscall indication. It then forms the next PC. A control-transfer instruction can be a conditional branch on operand equality, an absolute jump within the current 256 MB region, or a register-indirect jump. Otherwise the PC steps by four.

Linking jumps also request a write of the return address (PC+8) into general register 31. A syscall overrides everything else. It steers the PC to a fixed exception vector and requests two coprocessor writes in the same cycle: the cause value goes to coprocessor register 13 and the faulting PC goes to coprocessor register 14.

All results are registered, so they appear one clock after the inputs are sampled. A register-indirect target whose two low bits are not zero raises a flag for the core. The PC is still updated.

Top module: `npc_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `linkWe`, `causeWe`, `epcWe` and `misalignFetch` are 0 and `nextPc` is 0x00000000.
- R2: An accepted instruction that is not a control transfer (any opcode other than 0x00 with function 0x08/0x09, 0x02, 0x03, 0x04 or 0x05) gives `nextPc` = PC+4 one cycle later, with no write enable raised.
- R3: Opcode 0x04 gives PC + 4 + (sign-extended instruction bits [15:0] shifted left by 2) when `rsVal` equals `rtVal`, and PC+4 otherwise.
- R4: Opcode 0x05 takes the same branch target when `rsVal` differs from `rtVal`, and gives PC+4 when they are equal.
- R5: Opcode 0x02 gives a target built from PC bits [31:28] followed by instruction bits [25:0] and two zero bits. No link write is made.
- R6: Opcode 0x03 gives the same target as R5 and raises `linkWe` with `linkIdx` = 31 and `linkData` = PC+8.
- R7: Opcode 0x00 with function 0x08 gives `nextPc` = `rsVal`. No link write is made.
- R8: Opcode 0x00 with function 0x09 gives `nextPc` = `rsVal` and raises `linkWe` with `linkIdx` = 31 and `linkData` = PC+8.
- R9: `misalignFetch` is 1 exactly when an R7 or R8 jump has `rsVal[1:0]` not equal to 0. The PC is still set to `rsVal` in that case.
- R10: `sysCallIn` high on an accepted cycle gives `nextPc` = 0x80000080, `causeWe` with `causeData` = 0x20, and `epcWe` with `epcData` = PC. It raises no link or misalign output, whatever the instruction fields hold.
- R11: A cycle with `validIn` low gives `outValid` = 0 and all write enables and `misalignFetch` at 0 on the next cycle, and `nextPc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Inputs carry an instruction this cycle |
| pcIn | input | 32 | PC of the instruction |
| instrIn | input | 32 | Instruction word |
| rsVal | input | 32 | First source operand value |
| rtVal | input | 32 | Second source operand value |
| sysCallIn | input | 1 | Instruction is a system call |
| outValid | output | 1 | Registered results belong to an accepted instruction |
| nextPc | output | 32 | Next program counter |
| linkWe | output | 1 | Write return address to a general register |
| linkIdx | output | 5 | Index of the link register (31) |
| linkData | output | 32 | Return address PC+8 |
| causeWe | output | 1 | Write coprocessor register 13 (cause) |
| causeData | output | 32 | Cause value |
| epcWe | output | 1 | Write coprocessor register 14 (exception PC) |
| epcData | output | 32 | PC saved on exception entry |
| misalignFetch | output | 1 | Register-jump target not word aligned |

## Verification
The assertions check several things on every cycle. Trap entry always lands on the vector and writes cause and exception PC together. Any link write carries the PC+8 of the prior accepted instruction. Idle cycles raise no write and hold the PC. A misalign flag always comes with a target whose low bits are not zero. A not-equal branch never fires on equal operands. Only the bench's scenarios can show that the correct target is chosen for each opcode: region-relative formation across high PC regions, backward branch offsets, and the syscall override of a branch encoding. These are shown by comparing against a behavioural model on every clock.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JUMP    = 6'h02;
  localparam logic [5:0] OP_JLINK   = 6'h03;
  localparam logic [5:0] OP_BREQ    = 6'h04;
  localparam logic [5:0] OP_BRNE    = 6'h05;
  localparam logic [5:0] FN_REGJUMP = 6'h08;
  localparam logic [5:0] FN_REGLINK = 6'h09;

  // Strobes from the decoder to the target datapath
  typedef struct packed {
    logic trap;         // syscall entry
    logic jumpAbs;      // region-relative absolute jump
    logic jumpReg;      // register-indirect jump
    logic branchTaken;  // conditional branch resolved as taken
    logic link;         // write return address
  } npcStrobes_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        sysCallIn,
  input  logic [5:0]  opField,
  input  logic [5:0]  fnField,
  input  logic        opsEqual,
  output npcStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (validIn) begin
      if (sysCallIn) begin
        strobes.trap = 1'b1;
      end else begin
        case (opField)
          OP_SPECIAL: begin
            if (fnField == FN_REGJUMP) begin
              strobes.jumpReg = 1'b1;
            end else if (fnField == FN_REGLINK) begin
              strobes.jumpReg = 1'b1;
              strobes.link    = 1'b1;
            end
          end
          OP_JUMP:  strobes.jumpAbs = 1'b1;
          OP_JLINK: begin
            strobes.jumpAbs = 1'b1;
            strobes.link    = 1'b1;
          end
          OP_BREQ:  strobes.branchTaken = opsEqual;
          OP_BRNE:  strobes.branchTaken = !opsEqual;
          default:  ;
        endcase
      end
    end
  end

  // R10: trap entry never combines with a jump, branch or link
  a_r10_trap_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trap |-> !(strobes.jumpAbs || strobes.jumpReg || strobes.branchTaken || strobes.link));

  // R4: a not-equal branch with equal operands stays sequential
  a_r4_bne_equal_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !sysCallIn && opField == OP_BRNE && opsEqual) |-> !strobes.branchTaken);

  // R2: at most one target source selected
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.trap, strobes.jumpAbs, strobes.jumpReg, strobes.branchTaken}));

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          REGION_BITS = 4,
  parameter int          LINK_REG    = 31,
  parameter int          CAUSE_CODE  = 8,
  parameter int          CAUSE_SHIFT = 2,
  parameter logic [31:0] TRAP_VECTOR = 32'h8000_0080,
  parameter logic [31:0] RESET_PC    = 32'h0000_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [XLEN-1:0]      pcIn,
  input  logic [XLEN-REGION_BITS-3:0] jumpField,
  input  logic [15:0]          immField,
  input  logic [XLEN-1:0]      rsVal,
  input  logic [XLEN-1:0]      rtVal,
  input  npcStrobes_t          strobes,
  output logic                 opsEqual,
  output logic                 outValid,
  output logic [XLEN-1:0]      nextPc,
  output logic                 linkWe,
  output logic [4:0]           linkIdx,
  output logic [XLEN-1:0]      linkData,
  output logic                 causeWe,
  output logic [XLEN-1:0]      causeData,
  output logic                 epcWe,
  output logic [XLEN-1:0]      epcData,
  output logic                 misalignFetch
);

  localparam int IMM_W   = 16;
  localparam int EXT_W   = XLEN - IMM_W;
  localparam logic [XLEN-1:0] STEP     = XLEN'(4);
  localparam logic [XLEN-1:0] LINK_OFF = XLEN'(8);
  localparam logic [XLEN-1:0] CAUSE_VAL = XLEN'(CAUSE_CODE) << CAUSE_SHIFT;

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] linkVal;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] branchPc;
  logic [XLEN-1:0] regionPc;
  logic [XLEN-1:0] pcSel;
  logic            badAlign;

  assign opsEqual = (rsVal == rtVal);
  assign seqPc    = pcIn + STEP;
  assign linkVal  = pcIn + LINK_OFF;
  assign immExt   = {{EXT_W{immField[IMM_W-1]}}, immField};
  assign branchPc = seqPc + (immExt << 2);
  assign regionPc = {pcIn[XLEN-1 -: REGION_BITS], jumpField, 2'b00};
  assign badAlign = strobes.jumpReg && (rsVal[1:0] != 2'b00);

  always_comb begin
    if (strobes.trap)             pcSel = TRAP_VECTOR;
    else if (strobes.jumpReg)     pcSel = rsVal;
    else if (strobes.jumpAbs)     pcSel = regionPc;
    else if (strobes.branchTaken) pcSel = branchPc;
    else                          pcSel = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      nextPc        <= RESET_PC;
      linkWe        <= 1'b0;
      linkData      <= '0;
      causeWe       <= 1'b0;
      causeData     <= '0;
      epcWe         <= 1'b0;
      epcData       <= '0;
      misalignFetch <= 1'b0;
    end else begin
      outValid      <= validIn;
      linkWe        <= strobes.link && (LINK_REG != 0);
      causeWe       <= strobes.trap;
      epcWe         <= strobes.trap;
      misalignFetch <= badAlign;
      if (validIn) begin
        nextPc    <= pcSel;
        linkData  <= linkVal;
        causeData <= CAUSE_VAL;
        epcData   <= pcIn;
      end
    end
  end

  assign linkIdx = 5'(LINK_REG);

  // R10: trap lands on the vector and writes cause and exception PC together
  a_r10_trap_vector: assert property (@(posedge clk) disable iff (!rstN)
    causeWe |-> (nextPc == TRAP_VECTOR && epcWe && !linkWe && !misalignFetch));

  a_r10_epc_value: assert property (@(posedge clk) disable iff (!rstN)
    epcWe |-> (epcData == $past(pcIn) && causeData == CAUSE_VAL));

  // R6 / R8: link data is the prior PC plus 8, aimed at a nonzero register
  a_r6_link_value: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkData == $past(pcIn) + LINK_OFF && linkIdx != 5'd0));

  // R11: idle cycles raise nothing
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(linkWe || causeWe || epcWe || misalignFetch));

  a_r11_hold_pc: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(nextPc));

  // R9: misalign flag only with an unaligned target
  a_r9_misalign_target: assert property (@(posedge clk) disable iff (!rstN)
    misalignFetch |-> (nextPc[1:0] != 2'b00 && outValid));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] TRAP_VECTOR = 32'h8000_0080,
  parameter logic [31:0] RESET_PC    = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [31:0] pcIn,
  input  logic [31:0] instrIn,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  input  logic        sysCallIn,
  output logic        outValid,
  output logic [31:0] nextPc,
  output logic        linkWe,
  output logic [4:0]  linkIdx,
  output logic [31:0] linkData,
  output logic        causeWe,
  output logic [31:0] causeData,
  output logic        epcWe,
  output logic [31:0] epcData,
  output logic        misalignFetch
);

  localparam int XLEN        = 32;
  localparam int REGION_BITS = 4;
  localparam int JUMP_W      = XLEN - REGION_BITS - 2;

  npcStrobes_t strobes;
  logic        opsEqual;

  npc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .sysCallIn (sysCallIn),
    .opField   (instrIn[31:26]),
    .fnField   (instrIn[5:0]),
    .opsEqual  (opsEqual),
    .strobes   (strobes)
  );

  npc_datapath #(
    .XLEN        (XLEN),
    .REGION_BITS (REGION_BITS),
    .LINK_REG    (31),
    .CAUSE_CODE  (8),
    .CAUSE_SHIFT (2),
    .TRAP_VECTOR (TRAP_VECTOR),
    .RESET_PC    (RESET_PC)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .validIn       (validIn),
    .pcIn          (pcIn),
    .jumpField     (instrIn[JUMP_W-1:0]),
    .immField      (instrIn[15:0]),
    .rsVal         (rsVal),
    .rtVal         (rtVal),
    .strobes       (strobes),
    .opsEqual      (opsEqual),
    .outValid      (outValid),
    .nextPc        (nextPc),
    .linkWe        (linkWe),
    .linkIdx       (linkIdx),
    .linkData      (linkData),
    .causeWe       (causeWe),
    .causeData     (causeData),
    .epcWe         (epcWe),
    .epcData       (epcData),
    .misalignFetch (misalignFetch)
  );

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [31:0] pcIn = '0, instrIn = '0, rsVal = '0, rtVal = '0;
  logic        sysCallIn = 1'b0;
  logic        outValid, linkWe, causeWe, epcWe, misalignFetch;
  logic [31:0] nextPc, linkData, causeData, epcData;
  logic [4:0]  linkIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state for the cycle after the current drive
  bit          pending = 0;
  string       expReq;
  logic        eValid, eLink, eCause, eEpc, eMis;
  logic [31:0] eNext = 32'h0, eLinkData, eCauseData, eEpcData;

  always #4 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .pcIn(pcIn), .instrIn(instrIn),
    .rsVal(rsVal), .rtVal(rtVal), .sysCallIn(sysCallIn),
    .outValid(outValid), .nextPc(nextPc), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkData(linkData), .causeWe(causeWe), .causeData(causeData),
    .epcWe(epcWe), .epcData(epcData), .misalignFetch(misalignFetch)
  );

  task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
    $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
  endtask

  task automatic compare();
    bit bad = 0;
    checks++;
    if (outValid !== eValid) begin fail(expReq, "outValid", 32'(outValid), 32'(eValid)); bad = 1; end
    if (nextPc !== eNext) begin fail(expReq, "nextPc", nextPc, eNext); bad = 1; end
    if (linkWe !== eLink) begin fail(expReq, "linkWe", 32'(linkWe), 32'(eLink)); bad = 1; end
    if (causeWe !== eCause) begin fail(expReq, "causeWe", 32'(causeWe), 32'(eCause)); bad = 1; end
    if (epcWe !== eEpc) begin fail(expReq, "epcWe", 32'(epcWe), 32'(eEpc)); bad = 1; end
    if (misalignFetch !== eMis) begin fail(expReq, "misalignFetch", 32'(misalignFetch), 32'(eMis)); bad = 1; end
    if (eLink && (linkData !== eLinkData || linkIdx !== 5'd31)) begin
      fail(expReq, "linkData/idx", linkData, eLinkData); bad = 1;
    end
    if (eCause && causeData !== eCauseData) begin fail(expReq, "causeData", causeData, eCauseData); bad = 1; end
    if (eEpc && epcData !== eEpcData) begin fail(expReq, "epcData", epcData, eEpcData); bad = 1; end
    if (bad) errors++;
  endtask

  // behavioural reference: what the outputs should be one clock later
  task automatic model(bit v, logic [31:0] pc, logic [31:0] ins, logic [31:0] rs,
                       logic [31:0] rt, bit sc);
    int op = int'(ins[31:26]);
    int fn = int'(ins[5:0]);
    int off = int'($signed(ins[15:0])) * 4;
    eValid = v; eLink = 0; eCause = 0; eEpc = 0; eMis = 0;
    eLinkData = pc + 8; eCauseData = 32; eEpcData = pc;
    if (!v) return;
    if (sc) begin
      eNext = 32'h8000_0080; eCause = 1; eEpc = 1;
    end else if (op == 0 && (fn == 8 || fn == 9)) begin
      eNext = rs; eLink = (fn == 9); eMis = (rs % 4) != 0;
    end else if (op == 2 || op == 3) begin
      eNext = (pc & 32'hF000_0000) | ({6'b0, ins[25:0]} * 4);
      eLink = (op == 3);
    end else if ((op == 4 && rs == rt) || (op == 5 && rs != rt)) begin
      eNext = pc + 4 + 32'(off);
    end else begin
      eNext = pc + 4;
    end
  endtask

  task automatic step(string req, bit v, logic [31:0] pc, logic [31:0] ins,
                      logic [31:0] rs, logic [31:0] rt, bit sc);
    @(negedge clk);
    if (pending) compare();
    validIn = v; pcIn = pc; instrIn = ins; rsVal = rs; rtVal = rt; sysCallIn = sc;
    model(v, pc, ins, rs, rt, sc);
    expReq = req;
    pending = 1;
  endtask

  function automatic logic [31:0] mkI(int op, logic [15:0] imm);
    return {6'(op), 10'h0, imm};
  endfunction
  function automatic logic [31:0] mkJ(int op, logic [25:0] a);
    return {6'(op), a};
  endfunction
  function automatic logic [31:0] mkR(int fn);
    return {6'h0, 10'h155, 10'h0, 6'(fn)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (outValid !== 0 || linkWe !== 0 || causeWe !== 0 || epcWe !== 0 ||
        misalignFetch !== 0 || nextPc !== 32'h0) begin
      errors++;
      $display("FAIL R1 reset actual %h expected %h", nextPc, 32'h0);
    end
    rstN = 1'b1;

    step("R2", 1, 32'h0040_0000, mkR(6'h21), 32'h5, 32'h7, 0);
    step("R2", 1, 32'h0040_0004, mkI(6'h08, 16'hFFFF), 32'h5, 32'h5, 0);
    step("R3", 1, 32'h0040_0100, mkI(4, 16'hFFF0), 32'h1234, 32'h1234, 0);  // backward taken
    step("R3", 1, 32'h0040_0100, mkI(4, 16'h0010), 32'h1234, 32'h1235, 0);  // not taken
    step("R4", 1, 32'h0040_0200, mkI(5, 16'h0020), 32'h1, 32'h2, 0);        // taken
    step("R4", 1, 32'h0040_0200, mkI(5, 16'h0020), 32'h9, 32'h9, 0);        // not taken
    step("R5", 1, 32'hA123_4560, mkJ(2, 26'h3FF_FFFF), 0, 0, 0);
    step("R6", 1, 32'h7000_0010, mkJ(3, 26'h000_0040), 0, 0, 0);
    step("R7", 1, 32'h0040_0300, mkR(8), 32'h0050_0000, 0, 0);
    step("R8", 1, 32'h0040_0304, mkR(9), 32'h0060_0008, 0, 0);
    step("R9", 1, 32'h0040_0308, mkR(8), 32'h0060_0002, 0, 0);
    step("R9", 1, 32'h0040_030C, mkR(9), 32'h0060_0001, 0, 0);
    step("R10", 1, 32'h0040_0400, mkI(4, 16'h0008), 32'h3, 32'h3, 1);      // overrides branch
    step("R10", 1, 32'h0040_0404, mkR(9), 32'h0000_0003, 0, 1);            // overrides misaligned jalr
    step("R11", 0, 32'h1111_1111, mkJ(3, 26'h1), 32'h2, 32'h2, 1);
    step("R11", 0, 32'h2222_2222, mkR(9), 32'h3, 0, 0);
    step("R2", 1, 32'hFFFF_FFFC, mkR(0), 0, 1, 0);                          // wraps

    for (int i = 0; i < 600; i++) begin
      int k = int'($urandom_range(0, 9));
      logic [31:0] pc = $urandom & 32'hFFFF_FFFC;
      logic [31:0] rs = $urandom;
      logic [31:0] rt = ($urandom_range(0, 1) == 1) ? rs : $urandom;
      logic [31:0] ins;
      string r;
      bit v = ($urandom_range(0, 7) != 0);
      bit sc = 0;
      case (k)
        0: begin ins = mkI(4, 16'($urandom)); r = "R3"; end
        1: begin ins = mkI(5, 16'($urandom)); r = "R4"; end
        2: begin ins = mkJ(2, 26'($urandom)); r = "R5"; end
        3: begin ins = mkJ(3, 26'($urandom)); r = "R6"; end
        4: begin ins = mkR(8); r = "R7"; end
        5: begin ins = mkR(9); r = "R8"; end
        6: begin ins = $urandom; sc = 1; r = "R10"; end
        default: begin ins = {6'h23, 26'($urandom)}; r = "R2"; end
      endcase
      if (!v) r = "R11";
      step(r, v, pc, ins, rs, rt, sc);
    end
    step("R11", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule